// File: doc/BRIEF.md
# DMA Pointer-List Command Walker

This block sequences the transfer commands of one DMA channel. Software starts it by writing a single start word. The top three bits of that word give a command type, and the low 29 bits give the location of a list of 32-bit pointers. The walker reads that list one pointer at a time. Each pointer gives the base of an array of single-item descriptors. A descriptor is four words: command, source, destination and length.

For every descriptor the walker presents source, destination and length to an external mover. It holds that request until the mover signals completion, and only then fetches the next descriptor. A flag in each descriptor's command word ends its array. A flag in each pointer ends the list. When the final descriptor of the final pointer completes, the walker reports completion and goes idle. A descriptor that asks for any mode other than single-item stops the walk with an error. A start word of the wrong type does the same.

Memory is reached over a plain word-read port. A request is offered with valid/ready. The read data comes back later, marked by its own valid strobe.

Top module: `dma_list_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `xfer_req`, `walk_done` and `walk_err` are all low.
- R2: A `cfg_wr` while idle starts a walk only if `cfg_wdata[31:29]` equals 1. In that case the first memory read is at byte address `{cfg_wdata[28:0],3'b000}`. Any other type value pulses `walk_err` for one cycle and issues no memory read.
- R3: List pointers are read from consecutive word addresses, starting at the list base and stepping by 4. In each pointer, bits 28:0 shifted left by 3 give the descriptor array base, bit 31 marks the last pointer, and bits 30:29 have no effect.
- R4: A descriptor is read as four words at offsets 0, 4, 8 and 12 from its start, taken in the order command, source, destination, length. The next descriptor of the same array starts 16 bytes later.
- R5: If bits 1:0 of a command word are not 0 (1 = scatter-gather, 2 = indirect, 3 = box), the walker pulses `walk_err` for one cycle and returns to idle. It issues no mover request for that descriptor and makes no further memory read.
- R6: `xfer_req` stays high with `xfer_src`, `xfer_dst` and `xfer_len` stable until the cycle in which `xfer_done` is high. It drops in the following cycle. No memory read is offered while `xfer_req` is high.
- R7: When bit 31 of the command word is set, the next read after that descriptor completes is the next list pointer. Otherwise it is the next descriptor of the same array.
- R8: A memory request keeps `mem_req_valid` and `mem_req_addr` stable until `mem_req_ready` is high. Read data is taken only in a cycle where `mem_rsp_valid` is high.
- R9: When the descriptor with bit 31 set under a pointer with bit 31 set completes, `walk_done` is high for exactly one cycle, `busy` falls in that same cycle, and `walk_err` stays low.
- R10: A `cfg_wr` while `busy` is high has no effect on the walk in progress and starts no new walk afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Start-word write strobe |
| cfg_wdata | input | 32 | Start word: type in 31:29, list address field in 28:0 |
| mem_req_valid | output | 1 | Memory read request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 32 | Read data |
| xfer_req | output | 1 | Copy request to the mover |
| xfer_src | output | 32 | Source address of the copy |
| xfer_dst | output | 32 | Destination address of the copy |
| xfer_len | output | 32 | Length of the copy |
| xfer_done | input | 1 | Mover completion pulse |
| busy | output | 1 | Walk in progress |
| walk_done | output | 1 | One-cycle pulse: whole list finished |
| walk_err | output | 1 | One-cycle pulse: walk rejected or aborted |

## Verification
The bench drives the read-data bus with all ones whenever its valid strobe is low. A walker that captured data early would therefore see a box-mode, last-flagged command and abort. It walks a two-pointer list in which the last pointer also carries the ignored bits 30:29. A design that decoded those bits, or skipped the step to the next pointer, would fetch from the wrong array or stop too early. It places bad modes both in the first descriptor and in a later one, and checks that no mover request and no extra read follow. A walker that checked mode late would issue a copy or keep reading. It also writes a new start word in the middle of a walk and repeats the walk with a throttled ready signal. A design that restarted, or let its address move before acceptance, would show a read sequence different from the expected one.

// File: rtl/dma_list_walker.sv
module dma_list_walker #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [W-1:0] cfg_wdata,
  output logic         mem_req_valid,
  input  logic         mem_req_ready,
  output logic [W-1:0] mem_req_addr,
  input  logic         mem_rsp_valid,
  input  logic [W-1:0] mem_rsp_data,
  output logic         xfer_req,
  output logic [W-1:0] xfer_src,
  output logic [W-1:0] xfer_dst,
  output logic [W-1:0] xfer_len,
  input  logic         xfer_done,
  output logic         busy,
  output logic         walk_done,
  output logic         walk_err
);
  localparam int FW = W - 3;
  localparam logic [2:0] TYPE_PTR_LIST = 3'd1;

  typedef enum logic [2:0] {S_IDLE, S_PREQ, S_PWAIT, S_DREQ, S_DWAIT, S_XFER} st_t;

  st_t          st;
  logic [W-1:0] list_addr;
  logic [W-1:0] desc_addr;
  logic [1:0]   widx;
  logic         ptr_last;
  logic         desc_last;

  wire accept  = mem_req_valid && mem_req_ready;
  wire start   = cfg_wr && !busy;
  wire type_ok = cfg_wdata[W-1:W-3] == TYPE_PTR_LIST;

  assign busy          = st != S_IDLE;
  assign xfer_req      = st == S_XFER;
  assign mem_req_valid = (st == S_PREQ) || (st == S_DREQ);
  assign mem_req_addr  = (st == S_PREQ) ? list_addr : desc_addr + W'({widx, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      list_addr <= '0;
      desc_addr <= '0;
      widx      <= '0;
      ptr_last  <= 1'b0;
      desc_last <= 1'b0;
      xfer_src  <= '0;
      xfer_dst  <= '0;
      xfer_len  <= '0;
      walk_done <= 1'b0;
      walk_err  <= 1'b0;
    end else begin
      walk_done <= 1'b0;
      walk_err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (type_ok) begin
            list_addr <= {cfg_wdata[FW-1:0], 3'b000};
            st        <= S_PREQ;
          end else begin
            walk_err <= 1'b1;
          end
        end
        S_PREQ: if (accept) st <= S_PWAIT;
        S_PWAIT: if (mem_rsp_valid) begin
          desc_addr <= {mem_rsp_data[FW-1:0], 3'b000};
          ptr_last  <= mem_rsp_data[W-1];
          list_addr <= list_addr + W'(4);
          widx      <= '0;
          st        <= S_DREQ;
        end
        S_DREQ: if (accept) st <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: begin
              desc_last <= mem_rsp_data[W-1];
              if (mem_rsp_data[1:0] != 2'd0) begin
                walk_err <= 1'b1;
                st       <= S_IDLE;
              end else begin
                st <= S_DREQ;
              end
            end
            2'd1: begin xfer_src <= mem_rsp_data; st <= S_DREQ; end
            2'd2: begin xfer_dst <= mem_rsp_data; st <= S_DREQ; end
            default: begin xfer_len <= mem_rsp_data; st <= S_XFER; end
          endcase
        end
        S_XFER: if (xfer_done) begin
          if (!desc_last) begin
            desc_addr <= desc_addr + W'(16);
            widx      <= '0;
            st        <= S_DREQ;
          end else if (!ptr_last) begin
            st <= S_PREQ;
          end else begin
            walk_done <= 1'b1;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_xfer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_src) && $stable(xfer_dst) && $stable(xfer_len));

  assert_xfer_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done |=> !xfer_req);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> !busy && !walk_err);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  assert_start_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_wr));

  assert_err_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_err |-> !busy);
endmodule

// File: tb/dma_list_walker_tb_top.sv
`timescale 1ns/1ps
module dma_list_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'hFFFF_FFFF;
  logic        xfer_req;
  logic [31:0] xfer_src, xfer_dst, xfer_len;
  logic        xfer_done = 1'b0;
  logic        busy, walk_done, walk_err;

  always #2 clk = ~clk;

  dma_list_walker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len),
    .xfer_done(xfer_done), .busy(busy), .walk_done(walk_done), .walk_err(walk_err)
  );

  int tests = 0;
  int fails = 0;

  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:31];
  logic [31:0] xs_log [0:7];
  logic [31:0] xd_log [0:7];
  logic [31:0] xl_log [0:7];
  int rd_n, xf_n, done_n, err_n, overlap_n;
  int mem_lat = 1;
  bit slow_ready = 1'b0;
  bit pend = 1'b0;
  int pwait = 0;
  logic [31:0] paddr = '0;
  bit mv_active = 1'b0;
  int mv_cnt = 0;

  localparam logic [31:0] EXP_RD [0:13] = '{
    32'h100, 32'h200, 32'h204, 32'h208, 32'h20C, 32'h210, 32'h214,
    32'h218, 32'h21C, 32'h104, 32'h300, 32'h304, 32'h308, 32'h30C};
  localparam logic [31:0] EXP_XF [0:8] = '{
    32'h1000, 32'h2000, 32'h10,
    32'h1100, 32'h2100, 32'h20,
    32'h3000, 32'h4000, 32'h30};

  always @(negedge clk) begin
    if (pend) begin
      if (pwait > 1) begin
        pwait--;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'hFFFF_FFFF;
      end else begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem[paddr[9:2]];
        pend = 1'b0;
      end
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hFFFF_FFFF;
    end
    mem_req_ready = slow_ready ? ~mem_req_ready : 1'b1;
    if (mem_req_valid && mem_req_ready) begin
      if (rd_n < 32) rd_log[rd_n] = mem_req_addr;
      rd_n++;
      paddr = mem_req_addr;
      pend  = 1'b1;
      pwait = mem_lat;
    end
  end

  always @(negedge clk) begin
    if (xfer_done) begin
      xfer_done = 1'b0;
      mv_active = 1'b0;
    end else if (xfer_req && !mv_active) begin
      if (xf_n < 8) begin
        xs_log[xf_n] = xfer_src;
        xd_log[xf_n] = xfer_dst;
        xl_log[xf_n] = xfer_len;
      end
      xf_n++;
      mv_active = 1'b1;
      mv_cnt = 2;
    end else if (mv_active) begin
      if (mv_cnt > 1) mv_cnt--;
      else xfer_done = 1'b1;
    end
    if (walk_done) done_n++;
    if (walk_err) err_n++;
    if (xfer_req && mem_req_valid) overlap_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    rd_n = 0; xf_n = 0; done_n = 0; err_n = 0; overlap_n = 0;
  endtask

  task automatic launch(input logic [31:0] w, input bit poke);
    clear_logs();
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_wr = 1'b0;
    if (poke) begin
      repeat (8) @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = 32'h2000_0070;
      @(negedge clk); cfg_wr = 1'b0;
    end
    for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic check_main(input string tag);
    chk(rd_n == 14, {tag, " R4 read count"}, rd_n, 14);
    for (int i = 0; i < 14; i++)
      chk(rd_log[i] == EXP_RD[i], (i == 0) ? {tag, " R2 first read address"} :
          (i == 9) ? {tag, " R7 next pointer address"} : {tag, " R4 read address"},
          rd_log[i], EXP_RD[i]);
    chk(xf_n == 3, {tag, " R6 transfer count"}, xf_n, 3);
    for (int i = 0; i < 3; i++) begin
      chk(xs_log[i] == EXP_XF[3*i],   {tag, " R4 source"},      xs_log[i], EXP_XF[3*i]);
      chk(xd_log[i] == EXP_XF[3*i+1], {tag, " R4 destination"}, xd_log[i], EXP_XF[3*i+1]);
      chk(xl_log[i] == EXP_XF[3*i+2], {tag, " R4 length"},      xl_log[i], EXP_XF[3*i+2]);
    end
    chk(done_n == 1, {tag, " R9 done pulse count"}, done_n, 1);
    chk(err_n == 0, {tag, " R9 no error"}, err_n, 0);
    chk(overlap_n == 0, {tag, " R6 no read during transfer"}, overlap_n, 0);
    chk(busy == 1'b0, {tag, " R9 idle after walk"}, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[32'h100 >> 2] = 32'h0000_0040;
    mem[32'h104 >> 2] = 32'hE000_0060;
    mem[32'h200 >> 2] = 32'h0000_0AF0; mem[32'h204 >> 2] = 32'h1000; mem[32'h208 >> 2] = 32'h2000; mem[32'h20C >> 2] = 32'h10;
    mem[32'h210 >> 2] = 32'h8000_0000; mem[32'h214 >> 2] = 32'h1100; mem[32'h218 >> 2] = 32'h2100; mem[32'h21C >> 2] = 32'h20;
    mem[32'h300 >> 2] = 32'h8000_0000; mem[32'h304 >> 2] = 32'h3000; mem[32'h308 >> 2] = 32'h4000; mem[32'h30C >> 2] = 32'h30;
    mem[32'h180 >> 2] = 32'h8000_0068;
    mem[32'h340 >> 2] = 32'h8000_0003;
    mem[32'h1C0 >> 2] = 32'h8000_0070;
    mem[32'h380 >> 2] = 32'h0000_0000; mem[32'h384 >> 2] = 32'h5000; mem[32'h388 >> 2] = 32'h6000; mem[32'h38C >> 2] = 32'h40;
    mem[32'h390 >> 2] = 32'h0000_0001;

    clear_logs();
    repeat (3) @(negedge clk);
    chk(busy == 1'b0,          "R1 busy in reset",      busy, 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", mem_req_valid, 0);
    chk(xfer_req == 1'b0,      "R1 xfer_req in reset",  xfer_req, 0);
    chk(walk_done == 1'b0,     "R1 walk_done in reset", walk_done, 0);
    chk(walk_err == 1'b0,      "R1 walk_err in reset",  walk_err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    launch(32'h2000_0020, 1'b0);
    check_main("walk");

    mem_lat = 3; slow_ready = 1'b1;
    launch(32'h2000_0020, 1'b1);
    check_main("R10 R8 slow walk with busy write");
    mem_lat = 1; slow_ready = 1'b0;

    launch(32'h2000_0030, 1'b0);
    chk(err_n == 1, "R5 box mode error", err_n, 1);
    chk(xf_n == 0, "R5 no transfer on bad mode", xf_n, 0);
    chk(rd_n == 2, "R5 reads stop at command word", rd_n, 2);
    chk(rd_log[1] == 32'h340, "R3 array base from pointer", rd_log[1], 32'h340);
    chk(done_n == 0, "R5 no done on error", done_n, 0);

    launch(32'h2000_0038, 1'b0);
    chk(xf_n == 1, "R5 first descriptor transferred", xf_n, 1);
    chk(xs_log[0] == 32'h5000, "R5 source before abort", xs_log[0], 32'h5000);
    chk(err_n == 1, "R5 scatter-gather mode error", err_n, 1);
    chk(rd_n == 6, "R5 no read after bad command", rd_n, 6);
    chk(done_n == 0, "R5 no done after abort", done_n, 0);

    launch(32'h0000_0020, 1'b0);
    chk(err_n == 1, "R2 type 0 rejected", err_n, 1);
    chk(rd_n == 0, "R2 no read for type 0", rd_n, 0);
    launch(32'h6000_0020, 1'b0);
    chk(err_n == 1, "R2 type 3 rejected", err_n, 1);
    chk(rd_n == 0, "R2 no read for type 3", rd_n, 0);
    chk(busy == 1'b0, "R2 idle after reject", busy, 0);

    launch(32'h2000_0020, 1'b0);
    check_main("repeat walk");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule